// File: doc/BRIEF.md
# Complementary Dead-Band Generator

This block turns a PWM leg into a pair of gate-drive signals and keeps apart the switching edges of the two switches in a half bridge. Two delay paths sit between the PWM inputs and the gate outputs. The leading-edge path holds its output low until its source has stayed high for a programmed number of clock cycles. A source pulse shorter than that delay never reaches the output. The trailing-edge path keeps its output high for a programmed number of cycles after its source falls. Each path has its own enable bit. When the enable bit is clear, the path passes its source straight through.

A source select picks, for each path, either the A leg or the B leg of the PWM input. A two-bit inversion field can flip either gate output. The active-high complementary pair is set up as follows: both paths enabled, both sources on the A leg, and only the B output inverted. In that setup gate A is the edge-delayed copy of the A leg. Gate B is the inverse of the stretched A leg. The B input has no effect, and the two gates are never high in the same cycle.

Configuration is written through a small masked write port. Any single bit can be written without touching its neighbours, so the enables can be set one at a time. New values take effect the cycle after the write. The delay registers have no shadow copies.

Top module: `dead_band_gen`

## Requirements
- R1: After reset all configuration is zero, and both `gate_a` and `gate_b` follow `pwm_a_in` with no delay.
- R2: Writes load the register chosen by `cfg_addr` on the clock edge where `cfg_wr_en` is high. Address 0 is the control word: bit 0 enables the leading-edge path, bit 1 enables the trailing-edge path, bit 2 inverts gate A, bit 3 inverts gate B, bit 4 makes the leading-edge path take `pwm_b_in`, and bit 5 makes the trailing-edge path take `pwm_b_in`. Address 1 is the leading-edge delay and address 2 is the trailing-edge delay, both in clock cycles. Only bits whose `cfg_wmask` bit is 1 change.
- R3: Setting control bit 0 and control bit 1 with two separate single-bit masked writes gives the same output behaviour as writing both at once.
- R4: With the leading-edge path enabled and its delay D, its output rises after its source has been high across D rising clock edges, and it falls together with the source.
- R5: A source high pulse lasting fewer than D clock edges leaves the leading-edge output low throughout.
- R6: With the trailing-edge path enabled and its delay D, its output rises with the source and stays high for D clock edges after the source falls. Inversion is applied after this stretch.
- R7: A path whose enable bit is 0 passes its selected source through with no delay, whatever delay is programmed.
- R8: With a source-select bit at 0 the path is fed from `pwm_a_in`, and with it at 1 the path is fed from `pwm_b_in`. The leading-edge path drives `gate_a` and the trailing-edge path drives `gate_b`.
- R9: Inversion bit 2 flips `gate_a` and inversion bit 3 flips `gate_b`.
- R10: Complementary mode is control value 0x0B. In this mode `pwm_b_in` has no effect on either gate, and with both delays nonzero the two gates are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_a_in | input | 1 | PWM A leg |
| pwm_b_in | input | 1 | PWM B leg |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W (2) | Register select: 0 control, 1 leading delay, 2 trailing delay |
| cfg_wdata | input | DLY_W (10) | Write data |
| cfg_wmask | input | DLY_W (10) | Per-bit write enable |
| gate_a | output | 1 | Gate output A |
| gate_b | output | 1 | Gate output B |

## Verification
The gate outputs are combinational from the PWM inputs and the delay counters. An input change therefore shows up in the same cycle, while the delay counters move only on rising edges. The bench drives inputs on the falling edge and samples one time step later. The expected leading-edge output after k rising edges with the source high is (k >= D). The expected trailing-edge output j edges after the source falls is (j < D). A configuration write is counted as done one edge after the strobe, and every pulse sequence is preceded by a low settling stretch longer than the trailing delay, so that both counters start from zero.

// File: rtl/db_pkg.sv
package db_pkg;

    localparam int DB_DLY_W  = 10;
    localparam int DB_ADDR_W = 2;

    localparam int REG_CTL   = 0;
    localparam int REG_RISE  = 1;
    localparam int REG_FALL  = 2;

    localparam int NUM_PATHS = 2;
    localparam int PATH_LEAD = 0;
    localparam int PATH_TRAIL = 1;

    // en: path enables, inv: output inversion, src: 1 selects the B leg
    typedef struct packed {
        logic [1:0] src;
        logic [1:0] inv;
        logic [1:0] en;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    function automatic logic pick_src(input logic sel_b, input logic leg_a, input logic leg_b);
        return sel_b ? leg_b : leg_a;
    endfunction

    function automatic logic is_comp_pair(input ctl_t c);
        return (c.en == 2'b11) && (c.inv == 2'b10) && (c.src == 2'b00);
    endfunction

endpackage

// File: rtl/db_cfg_regs.sv
module db_cfg_regs
    import db_pkg::*;
#(
    parameter int DLY_W  = DB_DLY_W,
    parameter int ADDR_W = DB_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DLY_W-1:0]  wdata,
    input  logic [DLY_W-1:0]  wmask,
    output ctl_t              ctl,
    output logic [DLY_W-1:0]  rise_dly,
    output logic [DLY_W-1:0]  fall_dly
);

    logic [CTL_W-1:0] ctl_bits;
    logic             hit_ctl, hit_rise, hit_fall;

    assign hit_ctl  = wr_en && (addr == ADDR_W'(REG_CTL));
    assign hit_rise = wr_en && (addr == ADDR_W'(REG_RISE));
    assign hit_fall = wr_en && (addr == ADDR_W'(REG_FALL));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_bits <= '0;
            rise_dly <= '0;
            fall_dly <= '0;
        end else begin
            if (hit_ctl)
                ctl_bits <= (ctl_bits & ~wmask[CTL_W-1:0]) | (wdata[CTL_W-1:0] & wmask[CTL_W-1:0]);
            if (hit_rise)
                rise_dly <= (rise_dly & ~wmask) | (wdata & wmask);
            if (hit_fall)
                fall_dly <= (fall_dly & ~wmask) | (wdata & wmask);
        end
    end

    assign ctl = ctl_t'(ctl_bits);

endmodule

// File: rtl/db_edge_delay.sv
module db_edge_delay #(
    parameter int DLY_W   = 10,
    parameter bit TRAILING = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             src,
    input  logic [DLY_W-1:0] dly,
    output logic             dout
);

    logic [DLY_W-1:0] cnt_q;
    logic             shaped;

    generate
        if (TRAILING) begin : g_trail
            // reload while high, count down after the fall
            always_ff @(posedge clk) begin
                if (rst)
                    cnt_q <= '0;
                else if (src)
                    cnt_q <= dly;
                else if (cnt_q != '0)
                    cnt_q <= cnt_q - DLY_W'(1);
            end
            assign shaped = src | (cnt_q != '0);
        end else begin : g_lead
            // count consecutive high cycles, saturating at the delay
            always_ff @(posedge clk) begin
                if (rst || !src)
                    cnt_q <= '0;
                else if (cnt_q < dly)
                    cnt_q <= cnt_q + DLY_W'(1);
            end
            assign shaped = src & (cnt_q >= dly);
        end
    endgenerate

    assign dout = en ? shaped : src;

endmodule

// File: rtl/dead_band_gen.sv
module dead_band_gen
    import db_pkg::*;
#(
    parameter int DLY_W  = DB_DLY_W,
    parameter int ADDR_W = DB_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwm_a_in,
    input  logic              pwm_b_in,
    input  logic              cfg_wr_en,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DLY_W-1:0]  cfg_wdata,
    input  logic [DLY_W-1:0]  cfg_wmask,
    output logic              gate_a,
    output logic              gate_b
);

    ctl_t                  ctl_q;
    logic [DLY_W-1:0]      rise_dly_q, fall_dly_q;
    logic [NUM_PATHS-1:0]  path_src, path_out;
    logic [DLY_W-1:0]      path_dly [NUM_PATHS];

    db_cfg_regs #(.DLY_W(DLY_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr_en),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .wmask    (cfg_wmask),
        .ctl      (ctl_q),
        .rise_dly (rise_dly_q),
        .fall_dly (fall_dly_q)
    );

    assign path_dly[PATH_LEAD]  = rise_dly_q;
    assign path_dly[PATH_TRAIL] = fall_dly_q;

    generate
        for (genvar g = 0; g < NUM_PATHS; g++) begin : g_path
            assign path_src[g] = pick_src(ctl_q.src[g], pwm_a_in, pwm_b_in);

            db_edge_delay #(.DLY_W(DLY_W), .TRAILING(g == PATH_TRAIL)) u_dly (
                .clk  (clk),
                .rst  (rst),
                .en   (ctl_q.en[g]),
                .src  (path_src[g]),
                .dly  (path_dly[g]),
                .dout (path_out[g])
            );
        end
    endgenerate

    assign gate_a = path_out[PATH_LEAD]  ^ ctl_q.inv[PATH_LEAD];
    assign gate_b = path_out[PATH_TRAIL] ^ ctl_q.inv[PATH_TRAIL];

endmodule

// File: rtl/db_checker.sv
module db_checker
    import db_pkg::*;
#(
    parameter int DLY_W = DB_DLY_W
) (
    input logic             clk,
    input logic             rst,
    input logic             pwm_a_in,
    input logic             cfg_wr_en,
    input logic [DLY_W-1:0] cfg_wmask,
    input ctl_t             ctl_q,
    input logic [DLY_W-1:0] rise_dly_q,
    input logic [DLY_W-1:0] fall_dly_q,
    input logic             gate_a,
    input logic             gate_b
);

    assert_mask_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr_en && cfg_wmask == '0) |=> ($stable(ctl_q) && $stable(rise_dly_q) && $stable(fall_dly_q)));

    assert_lead_low_R4: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.en[0] && !ctl_q.src[0] && !ctl_q.inv[0] && rise_dly_q != '0
         && $stable(ctl_q) && !$past(pwm_a_in)) |-> !gate_a);

    assert_trail_high_R6: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.en[1] && !ctl_q.src[1] && !ctl_q.inv[1] && fall_dly_q != '0
         && $stable(ctl_q) && $stable(fall_dly_q) && $past(!rst) && $past(pwm_a_in)) |-> gate_b);

    assert_bypass_R7: assert property (@(posedge clk) disable iff (rst)
        (ctl_q == ctl_t'('0)) |-> (gate_a == pwm_a_in && gate_b == pwm_a_in));

    assert_no_overlap_R10: assert property (@(posedge clk) disable iff (rst)
        (is_comp_pair(ctl_q) && rise_dly_q != '0 && fall_dly_q != '0) |-> !(gate_a && gate_b));

endmodule

bind dead_band_gen db_checker #(.DLY_W(DLY_W)) u_db_checker (
    .clk        (clk),
    .rst        (rst),
    .pwm_a_in   (pwm_a_in),
    .cfg_wr_en  (cfg_wr_en),
    .cfg_wmask  (cfg_wmask),
    .ctl_q      (ctl_q),
    .rise_dly_q (rise_dly_q),
    .fall_dly_q (fall_dly_q),
    .gate_a     (gate_a),
    .gate_b     (gate_b)
);

// File: tb/dead_band_gen_bench.sv
module dead_band_gen_bench;

    localparam int DW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pwm_a_in = 1'b0;
    logic          pwm_b_in = 1'b0;
    logic          cfg_wr_en = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [DW-1:0] cfg_wmask = '0;
    logic          gate_a, gate_b;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dead_band_gen u_dead_band_gen (
        .clk(clk), .rst(rst), .pwm_a_in(pwm_a_in), .pwm_b_in(pwm_b_in),
        .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_wmask(cfg_wmask), .gate_a(gate_a), .gate_b(gate_b)
    );

    // complementary pair, leading 3, trailing 2: {pwm_a, pwm_b, exp_a, exp_b}
    localparam logic [3:0] VEC [20] = '{
        4'b0001, 4'b1100, 4'b1000, 4'b1100, 4'b1010, 4'b0100, 4'b0000, 4'b0101,
        4'b1100, 4'b1000, 4'b0100, 4'b0000, 4'b0001, 4'b1000, 4'b1100, 4'b1000,
        4'b1110, 4'b0000, 4'b0100, 4'b0001
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int addr, input logic [DW-1:0] data, input logic [DW-1:0] mask);
        cfg_wr_en = 1'b1;
        cfg_addr  = 2'(addr);
        cfg_wdata = data;
        cfg_wmask = mask;
        step();
        cfg_wr_en = 1'b0;
        cfg_wmask = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        pwm_a_in = 1'b0;
        pwm_b_in = 1'b0;
        repeat (3) step();
        rst = 1'b0;
    endtask

    // A-leg pulse; expected values follow R4/R6/R7/R9
    task automatic pulse(input string req, input int hi, input int lo, input int dr, input int df,
                         input logic [1:0] en, input logic [1:0] inv);
        pwm_a_in = 1'b0;
        repeat (df + 2) step();
        for (int k = 0; k < hi; k++) begin
            pwm_a_in = 1'b1;
            #1;
            check({req, " gate_a high"}, gate_a, (en[0] ? (k >= dr) : 1'b1) ^ inv[0]);
            check({req, " gate_b high"}, gate_b, 1'b1 ^ inv[1]);
            step();
        end
        for (int j = 0; j < lo; j++) begin
            pwm_a_in = 1'b0;
            #1;
            check({req, " gate_a low"}, gate_a, 1'b0 ^ inv[0]);
            check({req, " gate_b low"}, gate_b, (en[1] ? (j < df) : 1'b0) ^ inv[1]);
            step();
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1: reset state passes A to both gates
        pwm_a_in = 1'b1; #1;
        check("R1 gate_a", gate_a, 1'b1);
        check("R1 gate_b", gate_b, 1'b1);
        step();
        pwm_a_in = 1'b0; #1;
        check("R1 gate_a", gate_a, 1'b0);
        check("R1 gate_b", gate_b, 1'b0);
        step();

        // R2: a write with an all-zero mask changes nothing
        wr(0, '1, '0);
        pwm_a_in = 1'b1; #1;
        check("R2 zero mask gate_a", gate_a, 1'b1);
        check("R2 zero mask gate_b", gate_b, 1'b1);
        step();
        pwm_a_in = 1'b0;

        // R2/R4/R5/R6/R10: vector table in complementary mode
        wr(1, 10'd3, '1);
        wr(2, 10'd2, '1);
        wr(0, 10'h00B, '1);
        repeat (4) step();
        for (int i = 0; i < 20; i++) begin
            pwm_a_in = VEC[i][3];
            pwm_b_in = VEC[i][2];
            #1;
            check($sformatf("R10 vec %0d gate_a", i), gate_a, VEC[i][1]);
            check($sformatf("R10 vec %0d gate_b", i), gate_b, VEC[i][0]);
            step();
        end

        // R3: enables and inversion set bit by bit
        do_reset();
        wr(0, 10'h001, 10'h001);
        wr(0, 10'h002, 10'h002);
        wr(0, 10'h008, 10'h008);
        wr(1, 10'd3, '1);
        wr(2, 10'd2, '1);
        pulse("R3", 5, 4, 3, 2, 2'b11, 2'b10);
        // R5: pulse shorter than the leading delay
        pulse("R5", 2, 4, 3, 2, 2'b11, 2'b10);

        // R7: paths disabled, delays ignored
        wr(0, 10'h000, '1);
        pulse("R7", 4, 3, 3, 2, 2'b00, 2'b00);

        // R9: gate A inverted, leading path only
        wr(0, 10'h005, '1);
        pulse("R9", 4, 3, 3, 2, 2'b01, 2'b01);

        // R6: trailing path alone, delay 4
        wr(2, 10'd4, '1);
        wr(0, 10'h002, '1);
        pulse("R6", 3, 6, 3, 4, 2'b10, 2'b00);

        // R4: leading delay of one cycle
        wr(1, 10'd1, '1);
        wr(0, 10'h001, '1);
        pulse("R4", 3, 2, 1, 4, 2'b01, 2'b00);

        // R8: both paths take the B leg
        wr(0, 10'h030, '1);
        pwm_a_in = 1'b1; pwm_b_in = 1'b0; #1;
        check("R8 gate_a from B", gate_a, 1'b0);
        check("R8 gate_b from B", gate_b, 1'b0);
        step();
        pwm_a_in = 1'b0; pwm_b_in = 1'b1; #1;
        check("R8 gate_a from B", gate_a, 1'b1);
        check("R8 gate_b from B", gate_b, 1'b1);
        step();
        pwm_b_in = 1'b0;

        // R10: B leg has no effect in complementary mode
        wr(1, 10'd1, '1);
        wr(2, 10'd1, '1);
        wr(0, 10'h00B, '1);
        pwm_a_in = 1'b1;
        repeat (2) step();
        for (int i = 0; i < 4; i++) begin
            pwm_b_in = i[0]; #1;
            check("R10 B ignored gate_a", gate_a, 1'b1);
            check("R10 B ignored gate_b", gate_b, 1'b0);
            step();
        end
        pwm_a_in = 1'b0;
        repeat (3) step();
        for (int i = 0; i < 4; i++) begin
            pwm_b_in = ~i[0]; #1;
            check("R10 B ignored gate_a", gate_a, 1'b0);
            check("R10 B ignored gate_b", gate_b, 1'b1);
            step();
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule